// File: doc/BRIEF.md
# Conversion Result Holding Registers with Byte-Pair Interlock

This block keeps the most recent converter result in two byte-wide, read-only views: an upper byte and a lower byte. A single-cycle completion pulse comes with a 10-bit sample. If the block is free to take it, the sample is stored on that clock edge. Both byte views are driven combinationally from the stored value, so a bus read returns the held contents in the same cycle as its strobe.

A mode input selects between a 10-bit and an 8-bit result. In 10-bit mode the pair of bytes is read as a unit. Reading the upper byte arms a hold, so a later completion cannot mix a new lower byte with an old upper byte. Reading the lower byte releases the hold. Samples that arrive while the hold is armed are discarded, not queued. In 8-bit mode there is no hold, and every completion is stored.

Top module: `adc_result_hold`

## Requirements
- R1: After reset, both `rdata_hi` and `rdata_lo` read 0x00.
- R2: With no hold armed, a `conv_done` pulse stores `conv_data`. The new value appears on the byte outputs in the cycle after the pulse.
- R3: In 10-bit mode (`wide_mode`=1), a `rd_hi` pulse arms the hold. While the hold is armed, a `conv_done` pulse leaves both byte outputs unchanged.
- R4: A `rd_lo` pulse releases the hold. A sample dropped while the hold was armed never appears later. Only a completion after the release is stored.
- R5: A `conv_done` in the same cycle as a `rd_lo` that releases the hold is stored.
- R6: In 10-bit mode, a `conv_done` in the same cycle as a `rd_hi` is dropped, because the hold arms on that edge.
- R7: In 8-bit mode (`wide_mode`=0), `rd_hi` arms no hold, and every `conv_done` is stored.
- R8: In 10-bit mode, `rdata_hi` bits 1..0 carry result bits 9..8 and bits 7..2 read 0. `rdata_lo` carries result bits 7..0.
- R9: In 8-bit mode, only `conv_data[7:0]` is stored, `rdata_hi` reads 0x00 and `rdata_lo` carries result bits 7..0.
- R10: A change of `wide_mode` releases any armed hold on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 selects the 10-bit result, 0 selects the 8-bit result |
| conv_done | input | 1 | Single-cycle pulse: a conversion has finished |
| conv_data | input | 10 | Result that comes with `conv_done` |
| rd_hi | input | 1 | Single-cycle read strobe for the upper byte |
| rd_lo | input | 1 | Single-cycle read strobe for the lower byte |
| rdata_hi | output | 8 | Upper byte view of the held result |
| rdata_lo | output | 8 | Lower byte view of the held result |

## Verification
The assertions take every strobe to be a single-cycle pulse that is sampled on the rising edge. They also take `conv_data` to be meaningful only while `conv_done` is high. When a read strobe and a completion share a cycle, they resolve as described in R5 and R6. The stimulus changes inputs only on falling edges and returns every strobe to 0 after one cycle. Its random phase changes `wide_mode` rarely, so that long stretches inside each mode exercise the hold.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  localparam int RES_W  = 10;
  localparam int BYTE_W = 8;
  localparam int HI_W   = RES_W - BYTE_W;

  // keep the full sample in wide mode, only the lower byte in narrow mode
  function automatic logic [RES_W-1:0] fit_sample(input logic [RES_W-1:0] d,
                                                  input logic wide);
    logic [RES_W-1:0] r;
    r = d;
    if (!wide) r[RES_W-1:BYTE_W] = '0;
    return r;
  endfunction

  // next state of the hold flag; the release has priority over the arm
  function automatic logic next_hold(input logic cur, input logic flip,
                                     input logic wide, input logic rh,
                                     input logic rl);
    logic n;
    if (flip || rl)       n = 1'b0;
    else if (wide && rh)  n = 1'b1;
    else                  n = cur;
    return n;
  endfunction
endpackage

// File: rtl/adc_res_lock_ctrl.sv
module adc_res_lock_ctrl
  import adc_res_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wide_mode,
  input  logic conv_done,
  input  logic rd_hi,
  input  logic rd_lo,
  output logic hold_q,
  output logic mode_flip,
  output logic take
);
  logic mode_q;
  logic hold_d;

  assign mode_flip = (wide_mode != mode_q);
  assign hold_d    = next_hold(hold_q, mode_flip, wide_mode, rd_hi, rd_lo);
  // a sample is stored only if the hold is not in force after this edge
  assign take      = conv_done && !hold_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      mode_q <= wide_mode;
    end
  end
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store
  import adc_res_pkg::*;
#(
  parameter int W = RES_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         wide_mode,
  input  logic [W-1:0] conv_data,
  output logic [W-1:0] res_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    res_q <= '0;
    else if (take) res_q <= fit_sample(conv_data, wide_mode);
  end
endmodule

// File: rtl/adc_res_rdmux.sv
module adc_res_rdmux
  import adc_res_pkg::*;
(
  input  logic [RES_W-1:0]  res_q,
  input  logic              wide_mode,
  output logic [BYTE_W-1:0] rdata_hi,
  output logic [BYTE_W-1:0] rdata_lo
);
  assign rdata_lo = res_q[BYTE_W-1:0];

  for (genvar i = 0; i < BYTE_W; i++) begin : g_hi
    if (i < HI_W) begin : g_used
      assign rdata_hi[i] = res_q[BYTE_W+i] & wide_mode;
    end else begin : g_zero
      assign rdata_hi[i] = 1'b0;
    end
  end
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
  import adc_res_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              rd_hi,
  input  logic              rd_lo,
  output logic [BYTE_W-1:0] rdata_hi,
  output logic [BYTE_W-1:0] rdata_lo
);
  logic             hold_q;
  logic             mode_flip;
  logic             take;
  logic [RES_W-1:0] res_q;

  adc_res_lock_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .conv_done(conv_done),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .hold_q(hold_q), .mode_flip(mode_flip),
    .take(take)
  );

  adc_res_store #(.W(RES_W)) u_store (
    .clk(clk), .rst_n(rst_n), .take(take), .wide_mode(wide_mode),
    .conv_data(conv_data), .res_q(res_q)
  );

  adc_res_rdmux u_mux (
    .res_q(res_q), .wide_mode(wide_mode),
    .rdata_hi(rdata_hi), .rdata_lo(rdata_lo)
  );
endmodule

// File: rtl/adc_result_hold_chk.sv
module adc_result_hold_chk
  import adc_res_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wide_mode,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_data,
  input logic              rd_hi,
  input logic              rd_lo,
  input logic              hold_q,
  input logic              mode_flip,
  input logic [RES_W-1:0]  res_q,
  input logic [BYTE_W-1:0] rdata_hi,
  input logic [BYTE_W-1:0] rdata_lo
);
  p_capture_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !hold_q && !rd_hi) |=> rdata_lo == $past(conv_data[BYTE_W-1:0]));

  p_arm_on_hi_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && rd_hi && !rd_lo && !mode_flip) |=> hold_q);

  p_drop_when_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !rd_lo && !mode_flip) |=> $stable(res_q));

  p_release_on_lo_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> !hold_q);

  p_capture_on_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && hold_q && rd_lo) |=> rdata_lo == $past(conv_data[BYTE_W-1:0]));

  p_drop_with_hi_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && rd_hi && !rd_lo && !mode_flip) |=> $stable(res_q));

  p_no_hold_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && !mode_flip) |-> !hold_q);

  p_hi_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_hi[BYTE_W-1:HI_W] == '0);

  p_hi_zero_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |-> rdata_hi == '0);

  p_flip_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> !hold_q);
endmodule

bind adc_result_hold adc_result_hold_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .conv_done(conv_done),
  .conv_data(conv_data), .rd_hi(rd_hi), .rd_lo(rd_lo), .hold_q(hold_q),
  .mode_flip(mode_flip), .res_q(res_q), .rdata_hi(rdata_hi),
  .rdata_lo(rdata_lo)
);

// File: tb/adc_result_hold_tb.sv
`timescale 1ns/1ps
module adc_result_hold_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wide_mode = 1'b1;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic       rd_hi = 1'b0;
  logic       rd_lo = 1'b0;
  logic [7:0] rdata_hi, rdata_lo;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  adc_result_hold u_dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .conv_done(conv_done),
    .conv_data(conv_data), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .rdata_hi(rdata_hi), .rdata_lo(rdata_lo)
  );

  // reference model written from the requirements
  logic [9:0] m_res;
  logic       m_held, m_mode;

  function automatic logic [7:0] exp_hi(input logic [9:0] r, input logic w);
    return w ? {6'd0, r[9:8]} : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_res <= '0; m_held <= 1'b0; m_mode <= 1'b0;
    end else begin
      logic h;
      h = m_held;
      if (wide_mode != m_mode) h = 1'b0;       // R10
      else if (rd_lo) h = 1'b0;                // R4
      else if (wide_mode && rd_hi) h = 1'b1;   // R3
      if (conv_done && !h)
        m_res <= wide_mode ? conv_data : {2'b00, conv_data[7:0]};
      m_held <= h;
      m_mode <= wide_mode;
    end
  end

  task automatic check(input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_pair(input string tag, input logic [7:0] eh,
                            input logic [7:0] el);
    check(tag, rdata_hi, eh);
    check(tag, rdata_lo, el);
  endtask

  // drive one cycle at a falling edge, then drop strobes after the next rise
  task automatic cyc(input logic cd, input logic [9:0] d, input logic h,
                     input logic l);
    conv_done = cd; conv_data = d; rd_hi = h; rd_lo = l;
    @(negedge clk);
    conv_done = 1'b0; rd_hi = 1'b0; rd_lo = 1'b0;
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_pair("R1 reset", 8'h00, 8'h00);

    cyc(1, 10'h2A5, 0, 0);
    check_pair("R2 R8 capture wide", 8'h02, 8'hA5);

    cyc(0, 0, 1, 0);
    cyc(1, 10'h155, 0, 0);
    check_pair("R3 held drop", 8'h02, 8'hA5);

    cyc(0, 0, 0, 1);
    check_pair("R4 not queued", 8'h02, 8'hA5);
    cyc(1, 10'h0F3, 0, 0);
    check_pair("R4 after release", 8'h00, 8'hF3);

    cyc(1, 10'h3C1, 1, 0);
    check_pair("R6 same cycle hi read", 8'h00, 8'hF3);
    cyc(0, 0, 0, 1);

    cyc(0, 0, 1, 0);
    cyc(1, 10'h2D7, 0, 1);
    check_pair("R5 same cycle release", 8'h02, 8'hD7);

    cyc(0, 0, 1, 0);
    wide_mode = 1'b0; cyc(0, 0, 0, 0);
    wide_mode = 1'b1; cyc(0, 0, 0, 0);
    cyc(1, 10'h111, 0, 0);
    check_pair("R10 mode change release", 8'h01, 8'h11);

    wide_mode = 1'b0; cyc(0, 0, 0, 0);
    cyc(1, 10'h3EE, 0, 0);
    check_pair("R9 narrow layout", 8'h00, 8'hEE);
    cyc(0, 0, 1, 0);
    cyc(1, 10'h2AB, 0, 0);
    check_pair("R7 narrow no hold", 8'h00, 8'hAB);
    wide_mode = 1'b1; @(negedge clk);
    check("R9 upper bits dropped", rdata_hi, 8'h00);

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(15) == 0) wide_mode = ~wide_mode;
      cyc($urandom_range(2) == 0, 10'($urandom), $urandom_range(3) == 0,
          $urandom_range(3) == 0);
      check_pair("R2 R3 R4 R7 random", exp_hi(m_res, wide_mode), m_res[7:0]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule